// File: doc/BRIEF.md
# Printer Interface Activity Controller

This block sits between a host command port and a line printer data port. A one-bit activity flag decides whether host data may move to the printer. The host issues decoded commands, each a one-cycle strobe with a 2-bit opcode. The host offers data words one at a time into a single holding register. The printer pulls words from that register with a data request, and it is served only while the controller is active.

Every command gets exactly one response on the following cycle: an acknowledge or a reject. A status query is always answered and returns a snapshot of the internal flags. A self-test launch is refused while transfers are enabled or while a previous self-test is still running. An accepted self-test only starts a fixed-length busy window and reports when it is done; the test content itself lies outside this block. Four events force the controller idle: power-up reset, the master reset input, a device stop command and an end-of-block indication.

Top module: `prn_act_ctrl`

## Requirements
- R1: After power-up reset (rstN low) the controller is inactive and idle. hostReady is 1. prnStrobe, cmdAck, cmdRej, stStart and stDone are 0.
- R2: An enable command (opcode 2'b00) is acknowledged on the next cycle and makes the controller active.
- R3: Each cycle with cmdValid high produces exactly one of cmdAck or cmdRej on the next cycle. A cycle without cmdValid produces neither.
- R4: While active, a cycle with prnReq high and a pending word gives prnStrobe high on the next cycle, with that word on prnData. The holding register then empties.
- R5: A prnReq while inactive, or while no word is pending, is ignored: no prnStrobe, and any held word stays held.
- R6: The controller becomes inactive on a device stop command (opcode 2'b01), on endOfBlock, and on masterReset. masterReset also empties the holding register, clears the self-test busy flag and rejects any command given in the same cycle.
- R7: A status command (opcode 2'b10) is acknowledged in both states. With the acknowledge, statusValid is 1 and statusWord holds the flags as they were when the command was given: bit 2 word pending, bit 1 self-test busy, bit 0 active.
- R8: A self-test command (opcode 2'b11) is rejected while active. While inactive and not busy it is acknowledged, with stStart high in the same cycle as the acknowledge.
- R9: An accepted self-test keeps the busy flag set for 16 cycles. stDone pulses in the cycle that follows the last of those busy cycles, which is 16 cycles after the acknowledge. Self-test commands are rejected while busy.
- R10: hostReady is 1 exactly when no word is pending. A word is captured when hostValid and hostReady are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-up reset |
| cmdValid | input | 1 | Command strobe, one cycle per command |
| cmdOp | input | 2 | Command opcode |
| masterReset | input | 1 | Synchronous master reset, forces idle |
| prnReq | input | 1 | Printer data request |
| hostData | input | DW | Host data word |
| hostValid | input | 1 | Host data word valid |
| endOfBlock | input | 1 | End-of-block indication, forces inactive |
| hostReady | output | 1 | Holding register empty |
| prnData | output | DW | Word delivered to the printer |
| prnStrobe | output | 1 | prnData valid for one cycle |
| cmdAck | output | 1 | Command accepted |
| cmdRej | output | 1 | Command refused |
| statusValid | output | 1 | statusWord carries a fresh snapshot |
| statusWord | output | 3 | {pending, busy, active} snapshot |
| stStart | output | 1 | Self-test launch pulse |
| stDone | output | 1 | Self-test finished pulse |

## Verification
A wrong activity flag shows up one cycle after the next command. A self-test is then acknowledged where it should be rejected, or the reverse, and the next status snapshot shows the wrong bit 0. A lost or stale pending flag shows up on the next printer request: either prnStrobe goes missing or it fires with no word, and hostReady has the wrong level in the very next cycle. A wrong length for the busy counter moves the stDone pulse away from its fixed position 16 cycles after the acknowledge, and that position is checked cycle by cycle.

// File: rtl/prn_act_pkg.sv
`timescale 1ns/1ps
package prn_act_pkg;
  typedef enum logic [1:0] {
    OP_ENABLE = 2'b00,
    OP_STOP   = 2'b01,
    OP_STATUS = 2'b10,
    OP_TEST   = 2'b11
  } cmdOp_e;

  typedef struct packed {
    logic loadHold;
    logic sendWord;
    logic clearHold;
    logic captureStatus;
  } dpStrobe_t;
endpackage

// File: rtl/prn_act_ctrl_fsm.sv
`timescale 1ns/1ps
module prn_act_ctrl_fsm
  import prn_act_pkg::*;
#(
  parameter int ST_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       masterReset,
  input  logic       prnReq,
  input  logic       hostValid,
  input  logic       endOfBlock,
  input  logic       pending,
  output dpStrobe_t  strb,
  output logic       activeQ,
  output logic       busyQ,
  output logic       cmdAck,
  output logic       cmdRej,
  output logic       stStart,
  output logic       stDone
);
  localparam int CW = (ST_CYCLES > 2) ? $clog2(ST_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(ST_CYCLES - 1);

  cmdOp_e opDec;
  logic isEnable, isStop, isStatus, isTest;
  logic testOk, accept, nextActive;
  logic [CW-1:0] cnt;

  always_comb begin
    opDec    = cmdOp_e'(cmdOp);
    isEnable = cmdValid && (opDec == OP_ENABLE);
    isStop   = cmdValid && (opDec == OP_STOP);
    isStatus = cmdValid && (opDec == OP_STATUS);
    isTest   = cmdValid && (opDec == OP_TEST);
    testOk   = isTest && !activeQ && !busyQ && !masterReset;
    accept   = cmdValid && !masterReset && (!isTest || testOk);

    if (masterReset || endOfBlock || isStop) nextActive = 1'b0;
    else if (isEnable)                       nextActive = 1'b1;
    else                                     nextActive = activeQ;

    strb.loadHold      = hostValid && !pending && !masterReset;
    strb.sendWord      = prnReq && pending && activeQ && !masterReset;
    strb.clearHold     = masterReset;
    strb.captureStatus = isStatus && !masterReset;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      cmdAck  <= 1'b0;
      cmdRej  <= 1'b0;
      stStart <= 1'b0;
    end else begin
      activeQ <= nextActive;
      cmdAck  <= accept;
      cmdRej  <= cmdValid && !accept;
      stStart <= testOk;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      cnt    <= '0;
      stDone <= 1'b0;
    end else begin
      stDone <= busyQ && (cnt == '0) && !masterReset;
      if (masterReset) begin
        busyQ <= 1'b0;
        cnt   <= '0;
      end else if (testOk) begin
        busyQ <= 1'b1;
        cnt   <= LOAD_VAL;
      end else if (busyQ) begin
        if (cnt == '0) busyQ <= 1'b0;
        else           cnt   <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/prn_act_ctrl_dp.sv
`timescale 1ns/1ps
module prn_act_ctrl_dp
  import prn_act_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strb,
  input  logic [DW-1:0] hostData,
  input  logic          activeQ,
  input  logic          busyQ,
  output logic          pending,
  output logic [DW-1:0] prnData,
  output logic          prnStrobe,
  output logic          statusValid,
  output logic [2:0]    statusWord
);
  logic [DW-1:0] holdReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending   <= 1'b0;
      holdReg   <= '0;
      prnData   <= '0;
      prnStrobe <= 1'b0;
    end else begin
      prnStrobe <= strb.sendWord;
      if (strb.clearHold) begin
        pending <= 1'b0;
      end else if (strb.sendWord) begin
        pending <= 1'b0;
        prnData <= holdReg;
      end else if (strb.loadHold) begin
        pending <= 1'b1;
        holdReg <= hostData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusValid <= 1'b0;
      statusWord  <= '0;
    end else begin
      statusValid <= strb.captureStatus;
      if (strb.captureStatus) statusWord <= {pending, busyQ, activeQ};
    end
  end
endmodule

// File: rtl/prn_act_ctrl.sv
`timescale 1ns/1ps
module prn_act_ctrl
  import prn_act_pkg::*;
#(
  parameter int DW        = 8,
  parameter int ST_CYCLES = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  input  logic [1:0]    cmdOp,
  input  logic          masterReset,
  input  logic          prnReq,
  input  logic [DW-1:0] hostData,
  input  logic          hostValid,
  input  logic          endOfBlock,
  output logic          hostReady,
  output logic [DW-1:0] prnData,
  output logic          prnStrobe,
  output logic          cmdAck,
  output logic          cmdRej,
  output logic          statusValid,
  output logic [2:0]    statusWord,
  output logic          stStart,
  output logic          stDone
);
  dpStrobe_t strb;
  logic activeQ, busyQ, pending;

  prn_act_ctrl_fsm #(.ST_CYCLES(ST_CYCLES)) fsm_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .masterReset(masterReset), .prnReq(prnReq), .hostValid(hostValid),
    .endOfBlock(endOfBlock), .pending(pending), .strb(strb),
    .activeQ(activeQ), .busyQ(busyQ), .cmdAck(cmdAck), .cmdRej(cmdRej),
    .stStart(stStart), .stDone(stDone)
  );

  prn_act_ctrl_dp #(.DW(DW)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .hostData(hostData),
    .activeQ(activeQ), .busyQ(busyQ), .pending(pending),
    .prnData(prnData), .prnStrobe(prnStrobe),
    .statusValid(statusValid), .statusWord(statusWord)
  );

  assign hostReady = !pending;
endmodule

// File: rtl/prn_act_ctrl_chk.sv
`timescale 1ns/1ps
module prn_act_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdValid,
  input logic [1:0] cmdOp,
  input logic       endOfBlock,
  input logic       prnReq,
  input logic       prnStrobe,
  input logic       cmdAck,
  input logic       cmdRej,
  input logic       activeQ,
  input logic       busyQ
);
  // R3
  one_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> (cmdAck ^ cmdRej));

  // R3
  no_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> (!cmdAck && !cmdRej));

  // R4
  strobe_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    prnStrobe |-> $past(prnReq));

  // R5
  inactive_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !activeQ |=> !prnStrobe);

  // R6
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'b01) |=> !activeQ);

  // R6
  eob_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    endOfBlock |=> !activeQ);

  // R8
  test_active_rej_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'b11 && activeQ) |=> cmdRej);

  // R9
  test_busy_rej_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'b11 && busyQ) |=> cmdRej);
endmodule

bind prn_act_ctrl prn_act_ctrl_chk chk_i (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
  .endOfBlock(endOfBlock), .prnReq(prnReq), .prnStrobe(prnStrobe),
  .cmdAck(cmdAck), .cmdRej(cmdRej), .activeQ(activeQ), .busyQ(busyQ)
);

// File: tb/prn_act_ctrl_tb_top.sv
`timescale 1ns/1ps
module prn_act_ctrl_tb_top;
  localparam int DW = 8;
  localparam logic [1:0] C_EN = 2'b00, C_STOP = 2'b01, C_STAT = 2'b10, C_TEST = 2'b11;

  logic clk = 1'b0;
  logic rstN, cmdValid, masterReset, prnReq, hostValid, endOfBlock;
  logic [1:0] cmdOp;
  logic [DW-1:0] hostData;
  logic hostReady, prnStrobe, cmdAck, cmdRej, statusValid, stStart, stDone;
  logic [DW-1:0] prnData;
  logic [2:0] statusWord;
  int nVec = 0, nBad = 0;

  always #2.5 clk = ~clk;

  prn_act_ctrl #(.DW(DW), .ST_CYCLES(16)) dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .masterReset(masterReset), .prnReq(prnReq), .hostData(hostData),
    .hostValid(hostValid), .endOfBlock(endOfBlock), .hostReady(hostReady),
    .prnData(prnData), .prnStrobe(prnStrobe), .cmdAck(cmdAck), .cmdRej(cmdRej),
    .statusValid(statusValid), .statusWord(statusWord),
    .stStart(stStart), .stDone(stDone)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic cmd(input logic [1:0] op);
    cmdValid = 1'b1;
    cmdOp = op;
    tick();
    cmdValid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 hostReady", hostReady, 1);
    chk("R1 prnStrobe", prnStrobe, 0);
    chk("R1 ack/rej", {cmdAck, cmdRej}, 0);
    chk("R1 stStart/stDone", {stStart, stDone}, 0);
    cmd(C_STAT);
    chk("R7 status ack inactive", {cmdAck, cmdRej}, 2'b10);
    chk("R7 statusValid", statusValid, 1);
    chk("R1 status after reset", statusWord, 3'b000);
    tick();
    chk("R3 no strobe no response", {cmdAck, cmdRej}, 0);
  endtask

  task automatic t_transfer;
    hostData = 8'hA5; hostValid = 1'b1; tick(); hostValid = 1'b0;
    chk("R10 hostReady after load", hostReady, 0);
    prnReq = 1'b1; tick(); prnReq = 1'b0;
    chk("R5 req inactive no strobe", prnStrobe, 0);
    chk("R5 word held", hostReady, 0);
    cmd(C_EN);
    chk("R2 enable ack", {cmdAck, cmdRej}, 2'b10);
    cmd(C_STAT);
    chk("R7 status active pending", statusWord, 3'b101);
    prnReq = 1'b1; tick(); prnReq = 1'b0;
    chk("R4 strobe", prnStrobe, 1);
    chk("R4 data", prnData, 8'hA5);
    chk("R10 hostReady after send", hostReady, 1);
    prnReq = 1'b1; tick(); prnReq = 1'b0;
    chk("R5 no pending no strobe", prnStrobe, 0);
    hostData = 8'h3C; hostValid = 1'b1; tick(); hostValid = 1'b0;
    prnReq = 1'b1; tick(); prnReq = 1'b0;
    chk("R4 second word strobe", prnStrobe, 1);
    chk("R4 second word data", prnData, 8'h3C);
  endtask

  task automatic t_test_active;
    cmd(C_TEST);
    chk("R8 test rejected active", {cmdAck, cmdRej}, 2'b01);
    chk("R8 no start active", stStart, 0);
    cmd(C_STAT);
    chk("R7 status still active", statusWord, 3'b001);
  endtask

  task automatic t_idle_events;
    cmd(C_STOP);
    chk("R6 stop ack", {cmdAck, cmdRej}, 2'b10);
    cmd(C_STAT);
    chk("R6 inactive after stop", statusWord, 3'b000);
    cmd(C_EN);
    endOfBlock = 1'b1; tick(); endOfBlock = 1'b0;
    cmd(C_STAT);
    chk("R6 inactive after eob", statusWord, 3'b000);
    cmd(C_EN);
    hostData = 8'h77; hostValid = 1'b1; tick(); hostValid = 1'b0;
    masterReset = 1'b1; cmdValid = 1'b1; cmdOp = C_STAT; tick();
    masterReset = 1'b0; cmdValid = 1'b0;
    chk("R6 command rejected in master reset", {cmdAck, cmdRej}, 2'b01);
    chk("R6 master reset empties hold", hostReady, 1);
    cmd(C_STAT);
    chk("R6 inactive after master reset", statusWord, 3'b000);
  endtask

  task automatic t_selftest;
    int k;
    cmd(C_TEST);
    chk("R8 test accepted inactive", {cmdAck, cmdRej}, 2'b10);
    chk("R8 stStart", stStart, 1);
    cmd(C_TEST);
    chk("R9 test rejected busy", {cmdAck, cmdRej}, 2'b01);
    chk("R9 no restart while busy", stStart, 0);
    cmd(C_STAT);
    chk("R9 status busy", statusWord, 3'b010);
    k = 2;
    while (!stDone && k < 40) begin
      tick();
      k++;
    end
    chk("R9 stDone 16 cycles after accept", k, 16);
    tick();
    chk("R9 stDone single pulse", stDone, 0);
    cmd(C_TEST);
    chk("R9 test accepted after done", {cmdAck, cmdRej}, 2'b10);
    masterReset = 1'b1; tick(); masterReset = 1'b0;
    cmd(C_STAT);
    chk("R6 master reset clears busy", statusWord, 3'b000);
  endtask

  initial begin
    #(5.0 * 100000);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    rstN = 1'b0; cmdValid = 1'b0; cmdOp = 2'b00; masterReset = 1'b0;
    prnReq = 1'b0; hostValid = 1'b0; endOfBlock = 1'b0; hostData = '0;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    t_reset();
    t_transfer();
    t_test_active();
    t_idle_events();
    t_selftest();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule